// File: doc/BRIEF.md
# I2C Write-Only Control Register Receiver

This block is a write-only I2C target that holds two 7-bit control words for a frequency synthesizer: a channel word and a configuration word. A system clock much faster than the bus oversamples SCL and SDA. The block finds START and STOP, compares the address byte against a fixed device address, and shifts in each following byte MSB first. It acknowledges by enabling an open-drain pull-down on SDA. It never drives the line high.

The top bit of every data byte is a routing flag. A 1 sends the low seven bits to the channel word and a 0 sends them to the configuration word. A controller can therefore update both words in one transfer (flag 1 byte, then flag 0 byte), or update just one of them with a single-byte transfer. Every register load comes with a one-cycle write strobe for that register.

Top module: `i2cw_ctrl_rx`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `chan_q` and `cfg_q` are zero, and `sda_oe`, `chan_wr` and `cfg_wr` are low.
- R2: A START (SDA falling while SCL is high) begins address reception. A STOP (SDA rising while SCL is high) returns the block to idle from any point. SCL pulses seen while idle are ignored: no acknowledge and no write.
- R3: When the address byte equals 0xC0 on the wire (7-bit address 1100000, then write bit 0), `sda_oe` is high throughout the ninth SCL pulse. Each data byte received after that address is acknowledged the same way.
- R4: `sda_oe` rises within 10 clock cycles (200 ns at 50 MHz) of the SCL fall that ends bit 8. It falls within 10 cycles of the SCL fall that ends the ninth pulse. It never rises while SCL is high.
- R5: A data byte with bit 7 = 1 loads bits 6:0 into `chan_q`, and `chan_wr` pulses high for one cycle. `chan_q` changes only in a cycle where `chan_wr` is high.
- R6: A data byte with bit 7 = 0 loads bits 6:0 into `cfg_q`, and `cfg_wr` pulses high for one cycle. `cfg_q` changes only in a cycle where `cfg_wr` is high.
- R7: Any other address byte, including 0xC1 (read bit set), gets no acknowledge. The bytes after it get no acknowledge and cause no writes until the next START or STOP.
- R8: A data byte cut short by STOP or START after fewer than 8 bits writes nothing.
- R9: A repeated START in the middle of a transfer restarts address reception. The bytes after the new address are routed normally.
- R10: A third and any later data byte in one transfer is acknowledged and routed by its own bit 7.
- R11: `chan_wr` and `cfg_wr` are never high together, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high (open drain) |
| chan_q | output | 7 | Channel selection word |
| chan_wr | output | 1 | One-cycle strobe when `chan_q` is loaded |
| cfg_q | output | 7 | Configuration word |
| cfg_wr | output | 1 | One-cycle strobe when `cfg_q` is loaded |

## Verification
After an SCL edge at the pad, the block needs two synchronizer stages and one edge-compare before anything reacts. `sda_oe` therefore moves three clock edges after the SCL fall, and the register and its strobe change four edges after the SCL fall that ends bit 8. The bench holds SCL low for ten cycles after every fall. It counts the cycles until `sda_oe` moves and checks that count against the 10-cycle limit, then samples the acknowledge in the middle of the ninth SCL high phase. A behavioural model updates its expected register values and strobe counts only at the end of that ten-cycle window. The model is compared against the outputs on every falling clock edge outside the window.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int DATA_W = 7;
    localparam int BYTE_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_AACK,
        RX_DATA,
        RX_DACK,
        RX_SKIP
    } rx_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic              valid;
        logic              to_chan;
        logic [DATA_W-1:0] payload;
    } wr_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [DATA_W-1:0] dev);
        return b == {dev, 1'b0};
    endfunction

    function automatic wr_req_t make_req(input logic [BYTE_W-1:0] b);
        wr_req_t r;
        r.valid   = 1'b1;
        r.to_chan = b[BYTE_W-1];
        r.payload = b[DATA_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '1;
        else     pipe[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= '1;
            else     pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cw_events.sv
module i2cw_events
    import i2cw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2cw_frame.sv
module i2cw_frame
    import i2cw_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEV_ADDR = 7'h60
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t ev,
    output logic     ack_oe,
    output wr_req_t  req
);
    rx_state_t         st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            cnt    <= '0;
            sh     <= '0;
            ack_oe <= 1'b0;
            req    <= '0;
        end else begin
            req <= '0;
            if (ev.stop) begin
                st     <= RX_IDLE;
                ack_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= RX_ADDR;
                cnt    <= '0;
                ack_oe <= 1'b0;
            end else begin
                case (st)
                    RX_ADDR, RX_DATA: begin
                        if (ev.rise && cnt != CNT_W'(BYTE_W)) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall && cnt == CNT_W'(BYTE_W)) begin
                            cnt <= '0;
                            if (st == RX_ADDR) begin
                                if (addr_hit(sh, DEV_ADDR)) begin
                                    ack_oe <= 1'b1;
                                    st     <= RX_AACK;
                                end else begin
                                    st <= RX_SKIP;
                                end
                            end else begin
                                req    <= make_req(sh);
                                ack_oe <= 1'b1;
                                st     <= RX_DACK;
                            end
                        end
                    end
                    RX_AACK, RX_DACK: begin
                        if (ev.fall) begin
                            ack_oe <= 1'b0;
                            st     <= RX_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cw_ctrl_rx.sv
module i2cw_ctrl_rx
    import i2cw_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEV_ADDR    = 7'h60,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [DATA_W-1:0] chan_q,
    output logic              chan_wr,
    output logic [DATA_W-1:0] cfg_q,
    output logic              cfg_wr
);
    localparam int NREG = 2;

    logic [1:0] pins_s;
    bus_evt_t   ev;
    wr_req_t    req;

    logic [DATA_W-1:0] regs [NREG];
    logic [NREG-1:0]   wr;

    i2cw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (pins_s)
    );

    i2cw_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_s (pins_s[1]),
        .sda_s (pins_s[0]),
        .ev    (ev)
    );

    i2cw_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .ack_oe (sda_oe),
        .req    (req)
    );

    // index 0: channel word (flag 1), index 1: configuration word (flag 0)
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        assign hit = req.valid & (req.to_chan == (g == 0));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
                wr[g]   <= 1'b0;
            end else begin
                wr[g] <= hit;
                if (hit) regs[g] <= req.payload;
            end
        end
    end

    assign chan_q  = regs[0];
    assign cfg_q   = regs[1];
    assign chan_wr = wr[0];
    assign cfg_wr  = wr[1];
endmodule

// File: rtl/i2cw_ctrl_rx_chk.sv
module i2cw_ctrl_rx_chk
    import i2cw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [DATA_W-1:0] chan_q,
    input logic              chan_wr,
    input logic [DATA_W-1:0] cfg_q,
    input logic              cfg_wr
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (chan_q == '0 && cfg_q == '0 && !sda_oe && !chan_wr && !cfg_wr));

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chan_wr, cfg_wr}));

    // R11
    chan_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chan_wr |=> !chan_wr);

    // R11
    cfg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !cfg_wr);

    // R5
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_wr |-> chan_q == $past(chan_q));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |-> cfg_q == $past(cfg_q));

    // R4
    ack_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind i2cw_ctrl_rx i2cw_ctrl_rx_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .chan_q  (chan_q),
    .chan_wr (chan_wr),
    .cfg_q   (cfg_q),
    .cfg_wr  (cfg_wr)
);

// File: tb/sim_i2cw_ctrl_rx.sv
`timescale 1ns/1ps
module sim_i2cw_ctrl_rx;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line, sda_oe, chan_wr, cfg_wr;
    logic [6:0] chan_q, cfg_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit settle = 1'b1;
    int mstate = 0;               // 0 idle/ignore, 1 expect address, 2 data
    int exp_chan = 0, exp_cfg = 0;
    int exp_nc = 0, exp_ng = 0;
    int seen_nc = 0, seen_ng = 0;

    always #10 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    i2cw_ctrl_rx u0 (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .chan_q(chan_q), .chan_wr(chan_wr),
        .cfg_q(cfg_q), .cfg_wr(cfg_wr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (chan_wr) seen_nc++;
            if (cfg_wr)  seen_ng++;
            if (!settle) begin
                chk("R5 chan_q per clock", chan_q, exp_chan);
                chk("R6 cfg_q per clock", cfg_q, exp_cfg);
                chk("R5 chan_wr count", seen_nc, exp_nc);
                chk("R6 cfg_wr count", seen_ng, exp_ng);
            end
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_q(Q);
        scl_drv = 1'b1; wait_q(Q);
        sda_drv = 1'b0; wait_q(Q);
        scl_drv = 1'b0; wait_q(Q);
        mstate = 1;
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_q(Q);
        scl_drv = 1'b1; wait_q(Q);
        sda_drv = 1'b1; wait_q(Q);
        mstate = 0;
    endtask

    task automatic scl_low();
        scl_drv = 1'b0; wait_q(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b;    wait_q(Q);
        scl_drv = 1'b1; wait_q(2*Q);
        scl_drv = 1'b0; wait_q(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        bit exp_ack;
        int dly;
        exp_ack = (mstate == 1 && b == 8'hC0) || mstate == 2;
        for (int i = 7; i > 0; i--) send_bit(b[i]);
        sda_drv = b[0]; wait_q(Q);
        scl_drv = 1'b1; wait_q(2*Q);
        scl_drv = 1'b0;
        settle = 1'b1;
        dly = -1;
        for (int k = 1; k <= Q; k++) begin
            @(negedge clk);
            if (sda_oe && dly < 0) dly = k;
        end
        if (exp_ack) chk({tag, " R4 ack rise delay ok"}, (dly > 0 && dly <= 10), 1);
        else         chk({tag, " R7 no ack drive"}, (dly < 0), 1);
        if (mstate == 1) mstate = (b == 8'hC0) ? 2 : 0;
        else if (mstate == 2) begin
            if (b[7]) begin exp_chan = b[6:0]; exp_nc++; end
            else      begin exp_cfg  = b[6:0]; exp_ng++; end
        end
        settle = 1'b0;
        sda_drv = 1'b1;
        scl_drv = 1'b1; wait_q(Q);
        chk({tag, " R3 ack level"}, sda_oe, exp_ack);
        wait_q(Q);
        scl_drv = 1'b0;
        dly = -1;
        for (int k = 1; k <= Q; k++) begin
            @(negedge clk);
            if (!sda_oe && dly < 0) dly = k;
        end
        if (exp_ack) chk({tag, " R4 ack release delay ok"}, (dly > 0 && dly <= 10), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 chan_q in reset", chan_q, 0);
        chk("R1 cfg_q in reset", cfg_q, 0);
        chk("R1 sda_oe in reset", sda_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobes after reset", chan_wr | cfg_wr, 0);
        settle = 1'b0;
        wait_q(Q);

        // two-byte transfer (R3, R5, R6)
        bus_start();
        send_byte(8'hC0, "R3 addr");
        send_byte(8'hAA, "R5 chan");
        send_byte(8'h15, "R6 cfg");
        bus_stop();
        chk("R5 chan after pair", chan_q, 7'h2A);
        chk("R6 cfg after pair", cfg_q, 7'h15);

        // single-byte transfers
        bus_start(); send_byte(8'hC0, "R3 addr"); send_byte(8'h33, "R6 single"); bus_stop();
        bus_start(); send_byte(8'hC0, "R3 addr"); send_byte(8'hFF, "R5 single"); bus_stop();
        chk("R6 cfg single", cfg_q, 7'h33);
        chk("R5 chan single", chan_q, 7'h7F);

        // wrong address, and read bit set (R7)
        bus_start(); send_byte(8'hC2, "R7 bad addr"); send_byte(8'h85, "R7 after bad"); bus_stop();
        bus_start(); send_byte(8'hC1, "R7 read addr"); send_byte(8'h01, "R7 after read"); bus_stop();
        chk("R7 chan untouched", chan_q, 7'h7F);
        chk("R7 cfg untouched", cfg_q, 7'h33);

        // partial byte cut off by STOP (R8)
        bus_start(); send_byte(8'hC0, "R8 addr");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk("R8 chan after partial", chan_q, 7'h7F);
        chk("R8 cfg after partial", cfg_q, 7'h33);

        // partial byte cut off by repeated START, then new frame (R8, R9)
        bus_start(); send_byte(8'hC0, "R9 addr"); send_byte(8'h81, "R9 first");
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start(); send_byte(8'hC0, "R9 readdr"); send_byte(8'h05, "R9 second");
        bus_stop();
        chk("R9 chan", chan_q, 7'h01);
        chk("R9 cfg", cfg_q, 7'h05);

        // more than two data bytes (R10)
        bus_start(); send_byte(8'hC0, "R10 addr");
        send_byte(8'h90, "R10 b1"); send_byte(8'h20, "R10 b2"); send_byte(8'hC4, "R10 b3");
        send_byte(8'h0B, "R10 b4");
        bus_stop();
        chk("R10 chan third byte", chan_q, 7'h44);
        chk("R10 cfg fourth byte", cfg_q, 7'h0B);

        // STOP after address, then clocks without START are ignored (R2)
        bus_start(); send_byte(8'hC0, "R2 addr"); bus_stop();
        scl_low();
        send_byte(8'h85, "R2 idle clocks");
        send_byte(8'h12, "R2 idle clocks");
        chk("R2 chan after idle", chan_q, 7'h44);
        chk("R2 cfg after idle", cfg_q, 7'h0B);

        // fresh frame still works after all that (R2)
        bus_start(); send_byte(8'hC0, "R2 addr"); send_byte(8'h9C, "R2 chan"); bus_stop();
        chk("R2 chan final", chan_q, 7'h1C);
        chk("R11 chan strobes", seen_nc, exp_nc);
        chk("R11 cfg strobes", seen_ng, exp_ng);

        wait_q(Q);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule